// File: doc/BRIEF.md
# MSI Termination Register Bank

This block is the landing point for message-signalled interrupts. Each inbound write from the PCIe side names a frame and a termination register through its address, and a vector through its data value. The block records that event as a pending bit. The 2048 pending bits are arranged as 16 frames. Each frame holds 8 termination registers, and each register tracks 16 vectors.

The CPU reads a termination register to collect its pending vectors, and that read also clears them. Each frame also has a read-only summary register, which shows which of its registers hold work. Each frame drives one level interrupt, so a handler can locate its work by reading the summary first and then only the termination registers that summary names.

Both ports are simple strobes. A write is a valid, an address and data. A read is a valid and an address, and the answer is returned on the data output in the following cycle.

Top module: `msi_term_bank`

## Requirements
- R1: While reset is asserted and after it is released, every pending bit is clear, every `irq` bit is low and `cpuRdData` is zero.
- R2: A write with `msiWrAddr[23]`=0, `msiWrAddr[15:0]`=0 and `msiWrData` in 0..15 sets bit `msiWrData` of the termination register whose frame is `msiWrAddr[22:19]` and whose index is `msiWrAddr[18:16]`.
- R3: A read with `cpuRdAddr[23]`=0 and `cpuRdAddr[15:0]`=0 returns the pending bitmap of the register selected by bits 22:19 (frame) and 18:16 (index). The bitmap appears in `cpuRdData[15:0]`, with bits 31:16 zero, in the cycle after the request.
- R4: A termination-register read clears every pending bit it returned, so an immediate second read of that register returns zero.
- R5: A read with `cpuRdAddr[23:20]`=4'h8 and `cpuRdAddr[15:0]`=0 returns the summary of frame `cpuRdAddr[19:16]`. Bit x of `cpuRdData[7:0]` is 1 exactly when register x of that frame has any pending bit, and bits 31:8 are zero.
- R6: Summary reads have no side effect on any pending bit.
- R7: `irq[f]` is high exactly while frame f has at least one pending bit.
- R8: If a write sets a bit in the same cycle that a read clears the same register, the newly written bit stays pending. The read returns the contents held before that cycle.
- R9: A write with data above 15, or with an address outside the termination windows (bit 23 set or bits 15:0 non-zero), sets no bit.
- R10: A read of any other address returns zero and changes no pending bit.
- R11: In a cycle that follows no read request, `cpuRdData` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| msiWrValid | input | 1 | Inbound interrupt write strobe |
| msiWrAddr | input | 24 | Write offset within the bank |
| msiWrData | input | 32 | Vector number being signalled |
| cpuRdValid | input | 1 | CPU read strobe |
| cpuRdAddr | input | 24 | CPU read offset |
| cpuRdData | output | 32 | Read result, valid the cycle after the strobe |
| irq | output | 16 | Per-frame level interrupt |

## Verification
The bench targets a write and a clearing read that hit the same register in the same cycle. A design that applies the clear after the set would lose that interrupt, and a design that returns the new bit in the read would report it twice. It sends near-miss addresses and oversized data values, which a loose decoder would turn into spurious pending bits. It reads summaries repeatedly to catch a read path that wrongly clears state. A random phase, checked against a behavioural model on every clock, catches a mix-up in frame or index bit positions between the write decoder, the read decoder and the summary decoder.

// File: rtl/msi_term_pkg.sv
package msi_term_pkg;
  parameter int FRAMES = 16;
  parameter int REGS   = 8;
  parameter int VECS   = 16;
  parameter int ADDR_W = 24;
  parameter int DATA_W = 32;
  parameter int WIN_LSB = 16;   // each register owns a 2**WIN_LSB byte window

  localparam int FRAME_W = $clog2(FRAMES);
  localparam int REG_W   = $clog2(REGS);
  localparam int VEC_W   = $clog2(VECS);

  typedef enum logic [1:0] {RD_NONE, RD_TERM, RD_SUMM} rdKind_e;

  typedef struct packed {
    logic               setEn;
    logic [FRAME_W-1:0] setFrame;
    logic [REG_W-1:0]   setReg;
    logic [VEC_W-1:0]   setVec;
    logic               clrEn;
    logic [FRAME_W-1:0] clrFrame;
    logic [REG_W-1:0]   clrReg;
    rdKind_e            rdKind;
    logic [FRAME_W-1:0] rdFrame;
  } dpCtrl_t;
endpackage

// File: rtl/msi_term_ctrl.sv
module msi_term_ctrl
  import msi_term_pkg::*;
(
  input  logic              msiWrValid,
  input  logic [ADDR_W-1:0] msiWrAddr,
  input  logic [DATA_W-1:0] msiWrData,
  input  logic              cpuRdValid,
  input  logic [ADDR_W-1:0] cpuRdAddr,
  output dpCtrl_t           ctrl
);
  localparam int REG_LSB   = WIN_LSB;
  localparam int FRAME_LSB = WIN_LSB + REG_W;

  logic wrInWindow, wrDataOk, rdTermHit, rdSummHit;

  always_comb begin
    wrInWindow = !msiWrAddr[ADDR_W-1] && (msiWrAddr[WIN_LSB-1:0] == '0);
    wrDataOk   = (msiWrData[DATA_W-1:VEC_W] == '0);
    rdTermHit  = !cpuRdAddr[ADDR_W-1] && (cpuRdAddr[WIN_LSB-1:0] == '0);
    rdSummHit  = cpuRdAddr[ADDR_W-1]
                 && (cpuRdAddr[ADDR_W-2:WIN_LSB+FRAME_W] == '0)
                 && (cpuRdAddr[WIN_LSB-1:0] == '0);

    ctrl.setEn    = msiWrValid && wrInWindow && wrDataOk;
    ctrl.setFrame = msiWrAddr[FRAME_LSB +: FRAME_W];
    ctrl.setReg   = msiWrAddr[REG_LSB +: REG_W];
    ctrl.setVec   = msiWrData[VEC_W-1:0];

    ctrl.clrEn    = cpuRdValid && rdTermHit;
    ctrl.clrFrame = cpuRdAddr[FRAME_LSB +: FRAME_W];
    ctrl.clrReg   = cpuRdAddr[REG_LSB +: REG_W];

    if (!cpuRdValid) begin
      ctrl.rdKind  = RD_NONE;
      ctrl.rdFrame = '0;
    end else if (rdTermHit) begin
      ctrl.rdKind  = RD_TERM;
      ctrl.rdFrame = cpuRdAddr[FRAME_LSB +: FRAME_W];
    end else if (rdSummHit) begin
      ctrl.rdKind  = RD_SUMM;
      ctrl.rdFrame = cpuRdAddr[WIN_LSB +: FRAME_W];
    end else begin
      ctrl.rdKind  = RD_NONE;
      ctrl.rdFrame = '0;
    end
  end
endmodule

// File: rtl/msi_term_dp.sv
module msi_term_dp
  import msi_term_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctrl,
  output logic [DATA_W-1:0] cpuRdData,
  output logic [FRAMES-1:0] irq
);
  logic [VECS-1:0] pend [FRAMES][REGS];
  logic [REGS-1:0] summ [FRAMES];

  for (genvar f = 0; f < FRAMES; f++) begin : gFrame
    for (genvar r = 0; r < REGS; r++) begin : gReg
      logic hitSet, hitClr;
      logic [VECS-1:0] setMask, keepMask;
      always_comb begin
        hitSet   = ctrl.setEn && (ctrl.setFrame == f) && (ctrl.setReg == r);
        hitClr   = ctrl.clrEn && (ctrl.clrFrame == f) && (ctrl.clrReg == r);
        setMask  = hitSet ? (VECS'(1) << ctrl.setVec) : '0;
        keepMask = hitClr ? '0 : '1;
      end
      // clear first, then set: a colliding write survives the read
      always_ff @(posedge clk) begin
        if (!rstN) pend[f][r] <= '0;
        else       pend[f][r] <= (pend[f][r] & keepMask) | setMask;
      end
      assign summ[f][r] = |pend[f][r];
    end
    assign irq[f] = |summ[f];
  end

  logic [DATA_W-1:0] rdNext;
  always_comb begin
    rdNext = '0;
    unique case (ctrl.rdKind)
      RD_TERM: rdNext[VECS-1:0] = pend[ctrl.rdFrame][ctrl.clrReg];
      RD_SUMM: rdNext[REGS-1:0] = summ[ctrl.rdFrame];
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) cpuRdData <= '0;
    else       cpuRdData <= rdNext;
  end
endmodule

// File: rtl/msi_term_bank.sv
module msi_term_bank
  import msi_term_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              msiWrValid,
  input  logic [ADDR_W-1:0] msiWrAddr,
  input  logic [DATA_W-1:0] msiWrData,
  input  logic              cpuRdValid,
  input  logic [ADDR_W-1:0] cpuRdAddr,
  output logic [DATA_W-1:0] cpuRdData,
  output logic [FRAMES-1:0] irq
);
  dpCtrl_t ctrl;

  msi_term_ctrl uCtrl (
    .msiWrValid(msiWrValid), .msiWrAddr(msiWrAddr), .msiWrData(msiWrData),
    .cpuRdValid(cpuRdValid), .cpuRdAddr(cpuRdAddr), .ctrl(ctrl)
  );

  msi_term_dp uDp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .cpuRdData(cpuRdData), .irq(irq)
  );
endmodule

// File: rtl/msi_term_bank_chk.sv
module msi_term_bank_chk
  import msi_term_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              msiWrValid,
  input logic [ADDR_W-1:0] msiWrAddr,
  input logic [DATA_W-1:0] msiWrData,
  input logic              cpuRdValid,
  input logic [ADDR_W-1:0] cpuRdAddr,
  input logic [DATA_W-1:0] cpuRdData,
  input logic [FRAMES-1:0] irq
);
  assert_idle_data_R11: assert property (@(posedge clk) disable iff (!rstN)
    !$past(cpuRdValid) |-> cpuRdData == '0);

  assert_term_upper_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRdValid && !cpuRdAddr[ADDR_W-1]) |=> cpuRdData[DATA_W-1:VECS] == '0);

  assert_summ_upper_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRdValid && cpuRdAddr[ADDR_W-1]) |=> cpuRdData[DATA_W-1:REGS] == '0);

  assert_write_raises_irq_R7: assert property (@(posedge clk) disable iff (!rstN)
    (msiWrValid && !msiWrAddr[ADDR_W-1] && msiWrAddr[WIN_LSB-1:0] == '0
     && msiWrData[DATA_W-1:VEC_W] == '0)
    |=> irq[$past(msiWrAddr[ADDR_W-2 -: FRAME_W])]);

  assert_bad_data_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    (msiWrValid && msiWrData[DATA_W-1:VEC_W] != '0 && irq == '0) |=> irq == '0);
endmodule

bind msi_term_bank msi_term_bank_chk uChk (
  .clk(clk), .rstN(rstN), .msiWrValid(msiWrValid), .msiWrAddr(msiWrAddr),
  .msiWrData(msiWrData), .cpuRdValid(cpuRdValid), .cpuRdAddr(cpuRdAddr),
  .cpuRdData(cpuRdData), .irq(irq)
);

// File: tb/msi_term_bank_test.sv
module msi_term_bank_test;
  logic        clk = 0;
  logic        rstN = 0;
  logic        msiWrValid = 0;
  logic [23:0] msiWrAddr = '0;
  logic [31:0] msiWrData = '0;
  logic        cpuRdValid = 0;
  logic [23:0] cpuRdAddr = '0;
  logic [31:0] cpuRdData;
  logic [15:0] irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  int unsigned model [16][8];

  always #2.5 clk = ~clk;

  msi_term_bank uut (
    .clk(clk), .rstN(rstN), .msiWrValid(msiWrValid), .msiWrAddr(msiWrAddr),
    .msiWrData(msiWrData), .cpuRdValid(cpuRdValid), .cpuRdAddr(cpuRdAddr),
    .cpuRdData(cpuRdData), .irq(irq)
  );

  function automatic logic [23:0] termAddr(int f, int r);
    return 24'(f) << 19 | 24'(r) << 16;
  endfunction

  function automatic logic [23:0] summAddr(int f);
    return 24'h800000 | (24'(f) << 16);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: drive, let the model follow the requirements, then compare
  task automatic step(bit wv, logic [23:0] wa, logic [31:0] wd,
                      bit rv, logic [23:0] ra, string tag);
    logic [31:0] expRd;
    logic [15:0] expIrq;
    msiWrValid = wv; msiWrAddr = wa; msiWrData = wd;
    cpuRdValid = rv; cpuRdAddr = ra;
    @(posedge clk);
    expRd = '0;
    if (rv && !ra[23] && ra[15:0] == 0) begin
      expRd = model[ra[22:19]][ra[18:16]];
      model[ra[22:19]][ra[18:16]] = 0;
    end else if (rv && ra[23:20] == 4'h8 && ra[15:0] == 0) begin
      for (int r = 0; r < 8; r++)
        if (model[ra[19:16]][r] != 0) expRd[r] = 1'b1;
    end
    if (wv && !wa[23] && wa[15:0] == 0 && wd < 16)
      model[wa[22:19]][wa[18:16]] |= (32'd1 << wd[3:0]);
    expIrq = '0;
    for (int f = 0; f < 16; f++)
      for (int r = 0; r < 8; r++)
        if (model[f][r] != 0) expIrq[f] = 1'b1;
    #1;
    check(tag, cpuRdData, expRd);
    check({tag, "/R7 irq"}, {16'h0, irq}, {16'h0, expIrq});
  endtask

  task automatic wr(int f, int r, int v, string tag);
    step(1, termAddr(f, r), 32'(v), 0, '0, tag);
  endtask

  task automatic rd(logic [23:0] a, string tag);
    step(0, '0, '0, 1, a, tag);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int f = 0; f < 16; f++)
      for (int r = 0; r < 8; r++) model[f][r] = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset data", cpuRdData, 0);
    check("R1 reset irq", {16'h0, irq}, 0);
    // a write while reset is held must not stick
    msiWrValid = 1; msiWrAddr = termAddr(2, 1); msiWrData = 3;
    @(posedge clk); #1;
    msiWrValid = 0;
    rstN = 1;
    step(0, '0, '0, 0, '0, "R1 idle after reset");
    rd(termAddr(2, 1), "R1 no stale bit");

    wr(0, 0, 0, "R2 frame0 reg0 vec0");
    wr(5, 3, 9, "R2 frame5 reg3 vec9");
    wr(5, 3, 15, "R2 frame5 reg3 vec15");
    wr(15, 7, 4, "R2 frame15 reg7");
    step(0, '0, '0, 0, '0, "R11 idle");
    rd(summAddr(5), "R5 summary frame5");
    rd(summAddr(5), "R6 summary repeat");
    rd(summAddr(4), "R5 empty frame");
    rd(termAddr(5, 3), "R3 read frame5 reg3");
    rd(termAddr(5, 3), "R4 reread is zero");
    rd(summAddr(5), "R5 summary after clear");

    wr(9, 2, 1, "R2 setup collision");
    step(1, termAddr(9, 2), 32'd7, 1, termAddr(9, 2), "R8 collide read");
    rd(termAddr(9, 2), "R8 new bit survived");

    wr(3, 3, 16, "R9 data 16");
    wr(3, 3, 32'h8000_0002, "R9 high data bit");
    step(1, termAddr(3, 3) | 24'h000004, 32'd2, 0, '0, "R9 low addr bits");
    step(1, 24'h800000 | termAddr(3, 3), 32'd2, 0, '0, "R9 addr bit23");
    rd(termAddr(3, 3), "R9 nothing set");

    rd(24'h900000, "R10 unmapped high");
    rd(termAddr(0, 0) | 24'h000010, "R10 unmapped offset");
    rd(summAddr(0) | 24'h000100, "R10 summary offset bits");
    rd(termAddr(0, 0), "R10 no side effect");
    rd(termAddr(15, 7), "R3 frame15 reg7");

    for (int v = 0; v < 16; v++) wr(6, 5, v, "R2 all vectors");
    rd(summAddr(6), "R5 frame6");
    rd(termAddr(6, 5), "R3 full bitmap");

    for (int i = 0; i < 600; i++) begin
      int f = $urandom_range(0, 3) * 5;
      int r = $urandom_range(0, 7);
      int sel = $urandom_range(0, 5);
      logic [23:0] ra;
      if (sel < 3) ra = termAddr(f, r);
      else if (sel < 5) ra = summAddr(f);
      else ra = 24'hA00000;
      step($urandom_range(0, 3) != 0, termAddr(f, $urandom_range(0, 7)),
           32'($urandom_range(0, 17)), $urandom_range(0, 2) == 0, ra,
           "R8 random mix");
    end
    for (int f = 0; f < 16; f++)
      for (int r = 0; r < 8; r++) rd(termAddr(f, r), "R4 drain");
    step(0, '0, '0, 0, '0, "R7 all quiet");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule